// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in first-out store built from a bank of registers. It holds up to 64 data words, and a 6-bit pointer always addresses the word that is currently on top. A push request stores the word on the data input. A pop request returns the most recently stored word that has not yet been popped. Two one-bit status registers report when every slot is occupied (`full`) and when nothing is stored (`empty`).

On a push, the pointer moves up by one and the input word is then written into the slot the pointer now names. On a pop, the top word is copied into the output register and the pointer then moves down by one. The flags are recomputed from the pointer after every accepted operation. The block refuses three cases:
- a push when the stack is full;
- a pop when the stack is empty;
- a push and a pop requested in the same cycle.

In each refused case the cycle leaves the stack exactly as it was. The block is meant to sit beside a datapath that needs a small hardware stack, such as one holding return addresses or expression operands.

Top module: `lifo_reg_stack`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears: afterwards `empty` is 1, `full` is 0 and `dataOut` is 0.
- R2: Pops return words in the reverse order of the pushes that stored them (last in, first out).
- R3: Once 64 pushes have been accepted with no pops, `full` reads 1. With fewer than 64 words stored, `full` reads 0.
- R4: An accepted push leaves `empty` at 0. An accepted pop leaves `full` at 0.
- R5: The pop that removes the last stored word sets `empty` to 1. A pop that leaves at least one word behind keeps `empty` at 0.
- R6: A push while `full` is 1 is ignored: `full` stays 1, and the 64 stored words and their order are unchanged.
- R7: A pop while `empty` is 1 is ignored: `dataOut` keeps its value and `empty` stays 1.
- R8: When `push` and `pop` are both high in one cycle, neither operation happens: the flags, `dataOut` and the stored contents are unchanged.
- R9: `dataOut` changes only at the rising edge that accepts a pop. It shows the popped word from that edge until the next accepted pop.
- R10: `full` and `empty` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Request to store `dataIn` on top of the stack |
| pop | input | 1 | Request to remove the top word into `dataOut` |
| dataIn | input | DATA_W (16) | Word to store on a push |
| dataOut | output | DATA_W (16) | Last popped word, held in a register |
| full | output | 1 | High while all 64 slots are occupied |
| empty | output | 1 | High while no word is stored |

## Verification
Every result is due one clock edge after its request: the request is sampled at a rising edge, and `full`, `empty` and `dataOut` take their new values at that same edge. The bench therefore drives the request lines on the falling edge. It compares all three outputs a short delay after the next rising edge, against a bench-side model of the stored words that has been advanced by the same request. Because nothing takes more than one edge, every operation — accepted, refused or simultaneous — is checked in the cycle it takes effect. This also shows that a refused request alters nothing, since the following pops are compared against the unchanged model.

// File: rtl/stk_pkg.sv
package stk_pkg;

  // Strobes from the control to the pointer and datapath. At most one is high in any cycle.
  typedef struct packed {
    logic push;
    logic pop;
  } stkStrobe_t;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  stkStrobe_t       stb,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptrUp
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  assign ptrUp = ptr + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (stb.push) begin
      ptr <= ptrUp;
    end else if (stb.pop) begin
      ptr <= ptr - ONE;
    end
  end

  // R2: an accepted push moves the pointer to the slot just above the old top.
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    stb.push |=> (ptr == $past(ptrUp)));

  // R8: with no strobe the pointer holds still.
  p_ptr_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(stb.push || stb.pop) |=> $stable(ptr));

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic [PTR_W-1:0] ptr,
  output stkStrobe_t       stb,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] ptrNextUp;
  logic [PTR_W-1:0] ptrNextDn;

  assign ptrNextUp = ptr + ONE;
  assign ptrNextDn = ptr - ONE;

  // Refuse a push when full, a pop when empty, and any cycle that requests both.
  always_comb begin
    stb.push = pushReq && !popReq && !full;
    stb.pop  = popReq && !pushReq && !empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      empty <= 1'b1;
    end else if (stb.push) begin
      full  <= (ptrNextUp == '0);
      empty <= 1'b0;
    end else if (stb.pop) begin
      empty <= (ptrNextDn == '0);
      full  <= 1'b0;
    end
  end

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_push_clears_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (pushReq && !popReq && !full) |=> !empty);

  p_pop_clears_full_r4: assert property (@(posedge clk) disable iff (rst)
    (popReq && !pushReq && !empty) |=> !full);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (full && pushReq && !popReq) |=> full);

  p_empty_at_base_r5: assert property (@(posedge clk) disable iff (rst)
    empty |-> (ptr == '0));

  p_both_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (pushReq && popReq) |=> ($stable(full) && $stable(empty)));

endmodule

// File: rtl/stk_dpath.sv
module stk_dpath
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  stkStrobe_t        stb,
  input  logic [PTR_W-1:0]  wrAddr,
  input  logic [PTR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] slots [DEPTH];

  // The storage has no reset: a slot is only ever read after a push has written it.
  always_ff @(posedge clk) begin
    if (stb.push) begin
      slots[wrAddr] <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= '0;
    end else if (stb.pop) begin
      dataOut <= slots[rdAddr];
    end
  end

  // R9 and R7: the output register moves only at an accepted pop.
  p_dout_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !stb.pop |=> $stable(dataOut));

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !(stb.push && stb.pop));

endmodule

// File: rtl/lifo_reg_stack.sv
module lifo_reg_stack
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              full,
  output logic              empty
);

  // DEPTH must be a power of two so that the pointer wraps to zero exactly when the stack fills.
  localparam int PTR_W = $clog2(DEPTH);

  stkStrobe_t       stb;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrUp;

  stk_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .pushReq (push),
    .popReq  (pop),
    .ptr     (ptr),
    .stb     (stb),
    .full    (full),
    .empty   (empty)
  );

  stk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .ptr   (ptr),
    .ptrUp (ptrUp)
  );

  stk_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .wrAddr  (ptrUp),
    .rdAddr  (ptr),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/sim_lifo_reg_stack.sv
`timescale 1ns/1ps
module sim_lifo_reg_stack;

  localparam int DW   = 16;
  localparam int CAP  = 64;
  localparam int HALF = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          full;
  logic          empty;

  int checks = 0;
  int failures = 0;

  // Bench-side model of the stored words.
  logic [DW-1:0] model [CAP];
  int            cnt = 0;
  logic [DW-1:0] expOut = '0;

  lifo_reg_stack #(.DATA_W(DW), .DEPTH(CAP)) u0 (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .dataIn(dataIn), .dataOut(dataOut), .full(full), .empty(empty)
  );

  always #HALF clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Applies one request cycle, advances the model, then compares all outputs.
  task automatic step(input logic p, input logic q, input logic [DW-1:0] d);
    string doutTag;
    string fullTag;
    string emptyTag;
    @(negedge clk);
    push = p;
    pop = q;
    dataIn = d;
    doutTag = "R9";
    fullTag = "R3";
    emptyTag = "R4";
    if (p && q) begin
      doutTag = "R8"; fullTag = "R8"; emptyTag = "R8";
    end else if (p) begin
      if (cnt < CAP) begin
        model[cnt] = d;
        cnt++;
      end else begin
        fullTag = "R6";
      end
    end else if (q) begin
      if (cnt > 0) begin
        cnt--;
        expOut = model[cnt];
        doutTag = "R2";
        emptyTag = "R5";
      end else begin
        doutTag = "R7"; emptyTag = "R7";
      end
    end
    @(posedge clk);
    #2;
    check(doutTag, dataOut, expOut);
    check(fullTag, {15'd0, full}, {15'd0, cnt == CAP});
    check(emptyTag, {15'd0, empty}, {15'd0, cnt == 0});
    check("R10", {15'd0, full && empty}, 16'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: state right after reset
    check("R1", {15'd0, empty}, 16'd1);
    check("R1", {15'd0, full}, 16'd0);
    check("R1", dataOut, 16'd0);

    // R7: pop on an empty stack
    step(1'b0, 1'b1, 16'h0);
    // R4: single push, then R5: pop of the last word
    step(1'b1, 1'b0, 16'hA5A5);
    step(1'b0, 1'b1, 16'h0);
    // R3: fill to capacity
    for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, 16'(16'h1000 + i));
    // R6: pushes while full
    step(1'b1, 1'b0, 16'hDEAD);
    step(1'b1, 1'b0, 16'hBEEF);
    // R8: simultaneous request while full
    step(1'b1, 1'b1, 16'h7777);
    // R2: drain, checking the order
    for (int i = 0; i < CAP; i++) step(1'b0, 1'b1, 16'h0);
    step(1'b0, 1'b1, 16'h0);
    step(1'b1, 1'b1, 16'h3333);
    // R8: simultaneous request mid-stack
    step(1'b1, 1'b0, 16'h0101);
    step(1'b1, 1'b0, 16'h0202);
    step(1'b1, 1'b1, 16'h0303);
    step(1'b0, 1'b1, 16'h0);

    // Random phases, alternating between push-heavy and pop-heavy
    for (int ph = 0; ph < 12; ph++) begin
      for (int k = 0; k < 200; k++) begin
        int r;
        logic p;
        logic q;
        r = int'($urandom_range(99));
        p = (ph % 2 == 0) ? (r < 70) : (r < 25);
        q = (ph % 2 == 0) ? (r >= 60) : (r >= 20);
        step(p, q, 16'($urandom));
      end
    end

    @(negedge clk);
    push = 1'b0;
    pop = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule